// File: doc/BRIEF.md
# Eight-Pin General-Purpose Port with Serial-Receive Read Override

This block is one eight-pin general-purpose I/O port. A bus master writes a data register with a single-cycle strobe and reads it back through a combinational read bus. Each pin has a two-bit mode, supplied by a separate port-configuration block, and the mode decides three things: what a read of that pin's bit returns, whether the pin is driven, and whether its pull-up is on. Pin levels pass through a two-flop synchronizer before any read path can use them.

Three of the pins (bits 4, 2 and 0) also carry serial receive data. When the receive-enable flag from the serial controller is high, reads of those bits return the synchronized pin level whatever their mode is. Bit 7 has no storage and no driver. It only ever reports the pin level, and only when the pin is in an input mode.

Power-on reset clears the stored bits and forces every pin into input-with-pull-up behaviour while it is held. Manual reset and the low-power hold leave the stored bits unchanged.

Top module: `gpio_rx_port`

## Requirements
- R1: When `wr_en`=1 and `lp_hold`=0 at a rising edge, bits 6..0 of `wr_data` are stored at that edge. Bit 7 of `wr_data` is never stored.
- R2: Mode field `pin_mode[2i+1:2i]`=01 is general output. For bits 6..0, `rd_data[i]` returns the stored bit, `pin_oe[i]`=1, and `pin_out[i]` carries the stored bit.
- R3: Mode 10 is input with pull-up and mode 11 is input without pull-up. In both, `rd_data[i]` returns the synchronized pin level. `pin_pu[i]`=1 only in mode 10.
- R4: `rd_data[7]` is 0 in modes 00 and 01. `pin_oe[7]` and `pin_out[7]` are always 0.
- R5: Mode 00 is other function. For bits 6..0, `rd_data[i]` returns the stored bit, and `pin_oe[i]` and `pin_pu[i]` are 0.
- R6: While `rx_en`=1, `rd_data` bits 4, 2 and 0 return the synchronized pin level in every mode.
- R7: A rising edge with `por_n`=0 clears the stored bits and the synchronizer. While `por_n`=0, every pin behaves as mode 10: `pin_pu`=8'hFF and `pin_oe`=0.
- R8: `man_rst_n`=0 at an edge clears the synchronizer stages and leaves the stored bits unchanged.
- R9: While `lp_hold`=1, write strobes are ignored and the stored bits are retained.
- R10: A pin level that changes before edge k is not visible on `rd_data` after edge k. It is visible after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| man_rst_n | input | 1 | Manual reset, synchronous, active low |
| lp_hold | input | 1 | Sleep/standby hold; blocks writes |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, per-bit multiplexed |
| pin_mode | input | 16 | Two mode bits per pin, pin i at [2i+1:2i] |
| rx_en | input | 1 | Serial receiver enable; read override on bits 4, 2, 0 |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |

## Verification
Mode and receive-enable changes act on the read bus, output enables and pull-ups in the same cycle, because that path has no register. A write becomes visible one edge after the strobe. A pad change needs two edges. The bench drives every input at the falling edge and samples at a later falling edge. For each table vector it waits three edges so that the synchronizer has settled. The latency test samples once after one edge, expecting the old level, and once after two edges, expecting the new one. The reset tests follow the same rule and sample at the first falling edge after the reset edge.

// File: rtl/gpio_rx_pkg.sv
// gpio_rx_pkg: shared pin-mode encoding and the fixed port layout.
// Assumes two mode bits per pin, supplied by an external configuration block.
package gpio_rx_pkg;

    typedef enum logic [1:0] {
        PM_ALT     = 2'b00,  // pin serves another function
        PM_OUT     = 2'b01,  // general output
        PM_IN_PU   = 2'b10,  // general input, pull-up on
        PM_IN_NOPU = 2'b11   // general input, pull-up off
    } pin_mode_e;

    localparam int unsigned MODE_W = 2;

    // True when the mode reads the pin level back.
    function automatic logic mode_is_input(pin_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// gpio_sync: per-bit multi-stage synchronizer for asynchronous pad levels.
// Assumes rst_n is synchronous; reset clears every stage to 0.
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stage;

    // Shift the pad levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[LAST];

    // Count edges since reset, saturating, so the latency check below never
    // looks back past the last reset.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_lat2
            // R10: the output is the input sampled two edges earlier.
            p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst == 2'd3) |-> (q == $past(d, 2)));
        end
    endgenerate

endmodule

// File: rtl/gpio_data_reg.sv
// gpio_data_reg: port data storage. Read-only bit positions hold no state and
// read as 0 here. Cleared only by power-on reset. A write is accepted when
// the strobe is high and the low-power hold is low.
module gpio_data_reg #(
    parameter int unsigned      WIDTH   = 8,
    parameter logic [WIDTH-1:0] RO_MASK = 8'h80
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             lp_hold,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] stored
);

    localparam logic [WIDTH-1:0] RW_MASK = ~RO_MASK;

    logic accept;

    // Decide whether this cycle's strobe may update the register.
    always_comb accept = wr_en && !lp_hold;

    // Capture writable bits; power-on reset is the only clearing source.
    always_ff @(posedge clk) begin
        if (!por_n)      stored <= '0;
        else if (accept) stored <= wr_data & RW_MASK;
    end

    // R1: an accepted write lands at the next edge, read-only bits masked.
    p_write_r1: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !lp_hold) |=> (stored == ($past(wr_data) & RW_MASK)));

    // R9: during the low-power hold the contents never change.
    p_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
        lp_hold |=> $stable(stored));

endmodule

// File: rtl/gpio_pin_ctrl.sv
// gpio_pin_ctrl: per-pin mode decode, read multiplexing, output-enable and
// pull-up generation. Purely combinational. While in_por is high every pin
// is treated as input with pull-up. RX_MASK marks the pins whose reads the
// serial receive-enable overrides; RO_MASK marks pins with no storage.
module gpio_pin_ctrl
    import gpio_rx_pkg::*;
#(
    parameter int unsigned      WIDTH   = 8,
    parameter logic [WIDTH-1:0] RO_MASK = 8'h80,
    parameter logic [WIDTH-1:0] RX_MASK = 8'h15
) (
    input  logic                    in_por,
    input  logic [WIDTH*MODE_W-1:0] mode_bus,
    input  logic                    rx_en,
    input  logic [WIDTH-1:0]        stored,
    input  logic [WIDTH-1:0]        synced,
    output logic [WIDTH-1:0]        rd,
    output logic [WIDTH-1:0]        oe,
    output logic [WIDTH-1:0]        pu,
    output logic [WIDTH-1:0]        out
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            pin_mode_e eff;

            // Pick the mode in force: the reset default or the configured one.
            always_comb eff = in_por ? PM_IN_PU : pin_mode_e'(mode_bus[MODE_W*i +: MODE_W]);

            // Select the value a read of this bit returns.
            always_comb begin
                if (RX_MASK[i] && rx_en)  rd[i] = synced[i];
                else if (mode_is_input(eff)) rd[i] = synced[i];
                else if (RO_MASK[i])      rd[i] = 1'b0;
                else                      rd[i] = stored[i];
            end

            // Drive the pad only in output mode and only for stored bits.
            always_comb oe[i] = !RO_MASK[i] && (eff == PM_OUT);

            // Pull-up follows the input-with-pull-up mode.
            always_comb pu[i] = (eff == PM_IN_PU);

            // Pad level is the stored bit; read-only pins output 0.
            always_comb out[i] = RO_MASK[i] ? 1'b0 : stored[i];
        end
    endgenerate

endmodule

// File: rtl/gpio_rx_port.sv
// gpio_rx_port: eight-pin general-purpose port with a serial-receive read
// override. Assumes pin_in is asynchronous to clk, and that pin_mode and
// rx_en are already synchronous to clk. All resets are synchronous, active low.
module gpio_rx_port
    import gpio_rx_pkg::*;
#(
    parameter int unsigned  WIDTH       = 8,
    parameter int unsigned  SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] RO_MASK = 8'h80,
    parameter logic [WIDTH-1:0] RX_MASK = 8'h15
) (
    input  logic                    clk,
    input  logic                    por_n,
    input  logic                    man_rst_n,
    input  logic                    lp_hold,
    input  logic                    wr_en,
    input  logic [WIDTH-1:0]        wr_data,
    output logic [WIDTH-1:0]        rd_data,
    input  logic [WIDTH*MODE_W-1:0] pin_mode,
    input  logic                    rx_en,
    input  logic [WIDTH-1:0]        pin_in,
    output logic [WIDTH-1:0]        pin_out,
    output logic [WIDTH-1:0]        pin_oe,
    output logic [WIDTH-1:0]        pin_pu
);

    logic [WIDTH-1:0] stored;
    logic [WIDTH-1:0] synced;
    logic             sync_rst_n;

    // Either reset clears the synchronizer; only power-on clears the register.
    always_comb sync_rst_n = por_n && man_rst_n;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (sync_rst_n),
        .d     (pin_in),
        .q     (synced)
    );

    gpio_data_reg #(.WIDTH(WIDTH), .RO_MASK(RO_MASK)) u_reg (
        .clk     (clk),
        .por_n   (por_n),
        .lp_hold (lp_hold),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .stored  (stored)
    );

    gpio_pin_ctrl #(.WIDTH(WIDTH), .RO_MASK(RO_MASK), .RX_MASK(RX_MASK)) u_ctrl (
        .in_por   (!por_n),
        .mode_bus (pin_mode),
        .rx_en    (rx_en),
        .stored   (stored),
        .synced   (synced),
        .rd       (rd_data),
        .oe       (pin_oe),
        .pu       (pin_pu),
        .out      (pin_out)
    );

    // R8: a manual reset alone leaves the stored bits untouched.
    p_man_keep_r8: assert property (@(posedge clk) disable iff (!por_n)
        !man_rst_n |=> $stable(stored));

    // R7: while power-on reset is held, all pull-ups are on and nothing drives.
    p_por_default_r7: assert property (@(posedge clk)
        !por_n |-> (pin_pu == {WIDTH{1'b1}} && pin_oe == '0));

    // R4: read-only pins never drive their pad.
    p_ro_no_drive_r4: assert property (@(posedge clk) disable iff (!por_n)
        ((pin_oe & RO_MASK) == '0) && ((pin_out & RO_MASK) == '0));

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_chk
            if (RX_MASK[i]) begin : g_rx
                // R6: the receive enable makes the read report the pin.
                p_rx_priority_r6: assert property (@(posedge clk) disable iff (!por_n)
                    rx_en |-> (rd_data[i] == synced[i]));
            end
            if (RO_MASK[i]) begin : g_ro
                // R4: read-only bits read 0 outside the input modes.
                p_ro_low_r4: assert property (@(posedge clk) disable iff (!por_n)
                    !pin_mode[MODE_W*i+1] |-> !rd_data[i]);
            end
        end
    endgenerate

endmodule

// File: tb/gpio_rx_port_test.sv
// gpio_rx_port_test: a vector table walked by one loop, then directed tests
// for reset, latency, manual reset and low-power hold.
module gpio_rx_port_test;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        man_rst_n = 1'b0;
    logic        lp_hold = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [15:0] pin_mode = 16'hAAAA;
    logic        rx_en = 1'b0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe, pin_pu;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    gpio_rx_port uut (
        .clk(clk), .por_n(por_n), .man_rst_n(man_rst_n), .lp_hold(lp_hold),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pin_mode(pin_mode), .rx_en(rx_en), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    // Vector: {mode16, rx (byte), pins, expected rd, expected oe}.
    // The register holds 8'h5A while the table runs.
    localparam int NV = 8;
    localparam logic [47:0] VEC [NV] = '{
        {16'h5555, 8'h00, 8'hFF, 8'h5A, 8'h7F},  // R2 R4 all output
        {16'hAAAA, 8'h00, 8'hA5, 8'hA5, 8'h00},  // R3 input with pull-up
        {16'hFFFF, 8'h00, 8'h3C, 8'h3C, 8'h00},  // R3 input without pull-up
        {16'h0000, 8'h00, 8'hFF, 8'h5A, 8'h00},  // R5 R4 other function
        {16'h5555, 8'h01, 8'hFF, 8'h5F, 8'h7F},  // R6 override in output mode
        {16'h0000, 8'h01, 8'h00, 8'h4A, 8'h00},  // R6 override in other mode
        {16'hAA55, 8'h00, 8'h0F, 8'h0A, 8'h0F},  // R2 R3 mixed modes
        {16'hAA55, 8'h01, 8'hF5, 8'hFF, 8'h0F}   // R6 mixed modes
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected pull-up enables: 1 where the pin's mode is 10 (R3).
    function automatic logic [7:0] exp_pu(input logic [15:0] m);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = (m[2*i +: 2] == 2'b10);
        return r;
    endfunction

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] v);
        wr_data = v; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        // R7: during power-on reset the pins default to input with pull-up.
        pin_mode = 16'h5555;
        tick(3);
        check("R7 pu during por", pin_pu, 8'hFF);
        check("R7 oe during por", pin_oe, 8'h00);
        por_n = 1'b1; man_rst_n = 1'b1;
        tick(1);
        check("R7 register cleared", rd_data, 8'h00);

        // R1: bit 7 of the write data is dropped.
        write_reg(8'hDA);
        check("R1 write stored", rd_data, 8'h5A);
        check("R2 pin_out", pin_out, 8'h5A);

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            pin_mode = VEC[v][47:32];
            rx_en    = VEC[v][24];
            pin_in   = VEC[v][23:16];
            tick(3);
            check($sformatf("vec%0d rd R2/R3/R4/R5/R6", v), rd_data, VEC[v][15:8]);
            check($sformatf("vec%0d oe R2/R4", v), pin_oe, VEC[v][7:0]);
            check($sformatf("vec%0d pu R3", v), pin_pu, exp_pu(VEC[v][47:32]));
        end
        rx_en = 1'b0;

        // R10: two-edge latency from pad to read.
        pin_mode = 16'hAAAA; pin_in = 8'h00;
        tick(3);
        pin_in = 8'hFF;
        tick(1);
        check("R10 not yet after one edge", rd_data, 8'h00);
        tick(1);
        check("R10 visible after two edges", rd_data, 8'hFF);

        // R8: manual reset clears the synchronizer but keeps the register.
        man_rst_n = 1'b0;
        tick(1);
        man_rst_n = 1'b1;
        check("R8 sync cleared", rd_data, 8'h00);
        tick(2);
        check("R8 sync refilled", rd_data, 8'hFF);
        pin_mode = 16'h5555;
        #1;
        check("R8 register kept", rd_data, 8'h5A);

        // R9: writes are ignored during the low-power hold.
        lp_hold = 1'b1;
        write_reg(8'h11);
        check("R9 write blocked", rd_data, 8'h5A);
        lp_hold = 1'b0;
        write_reg(8'h23);
        check("R1 write after hold", rd_data, 8'h23);

        // R7: power-on reset clears a non-zero register.
        por_n = 1'b0;
        tick(1);
        por_n = 1'b1;
        #1;
        check("R7 por clears", rd_data, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule